// File: doc/BRIEF.md
# Serial Flash Boot Recovery Sequencer

After any reset, a serial NOR flash may still be in a four-wire or two-wire data mode left over from earlier firmware. It may also be finishing an internal operation. This block runs straight out of reset and brings the flash back to plain single-bit SPI. It proves that a device is present and ready, then starts a sequential read from address zero. The received bytes are handed to the boot loader as a stream.

The recovery is blind, because the current mode of the device cannot be known. The block sends three short all-ones bursts, each in its own chip-select frame, of 8, 16 and 2 clocks. It then sends the software-reset pair. The exit time from reset varies widely between parts and states, so the block uses no fixed delay. Instead it keeps polling the identification command until the manufacturer byte looks real, or until a time budget runs out.

The SPI clock is derived from the system clock, with `HALF_DIV` system cycles per SCK half period. The two upper data lines of the flash are driven high for the whole run.

Top module: `fboot_seq`

## Requirements
- R1: After reset is released, the first three chip-select frames carry 8, 16 and 2 SCK clocks respectively, with MOSI high for every clock.
- R2: The next two frames are 8 clocks each and carry 0x66 and then 0x99, MSB first.
- R3: Next come identification frames of 32 clocks. Each frame's first 8 bits are 0x9F, MSB first, and the remaining bits are ones. They repeat until the first response byte (MISO bits 8 to 15 of the frame) is neither 0x00 nor 0xFF.
- R4: Polling gives up only if an identification frame ends invalid after `TIMEOUT_CYC` system cycles have elapsed since polling began. `boot_fail` then rises, chip select stays high, and no read frame is issued.
- R5: After a valid ID, a single frame carries 0x03 and a 24-bit zero address, followed by `READ_BYTES` data bytes, all MSB first.
- R6: Each data byte appears on `rd_byte` with `rd_valid` high for exactly one cycle, in order. After the last byte, chip select is released and `boot_done` rises.
- R7: Transfers use SPI mode 0. SCK is low whenever chip select is high, MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge.
- R8: Between frames, chip select stays high for at least `GAP_SCK` SCK periods (2 × `GAP_SCK` × `HALF_DIV` system cycles).
- R9: A synchronous `rst` at any time returns chip select high, clears both flags, and restarts the whole sequence from the 8-clock burst.
- R10: `flash_io2` and `flash_io3` are high at all times.
- R11: `boot_done` and `boot_fail` are never high together, and each stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |
| flash_io2 | output | 1 | Upper data line, held high |
| flash_io3 | output | 1 | Upper data line, held high |
| rd_byte | output | 8 | Received boot byte |
| rd_valid | output | 1 | One-cycle strobe for rd_byte |
| boot_done | output | 1 | All boot bytes delivered |
| boot_fail | output | 1 | No valid device within the time budget |

## Verification
A wrong phase or a miscounted bit shows up at the pins first. If an exit burst or reset command is skipped or reordered, the shape of a chip-select frame is wrong as soon as that frame closes, well before any data arrives. A faulty shift or sample stage corrupts the head of the very next frame or the first streamed byte. A faulty retry or timeout path shows as a fail flag raised too early or too late relative to the first identification frame, or as a read frame that should never appear.

// File: rtl/fboot_pkg.sv
package fboot_pkg;
    typedef enum logic [3:0] {
        PH_EXIT_Q,
        PH_EXIT_D,
        PH_EXIT_N,
        PH_RST_EN,
        PH_RST_GO,
        PH_ID,
        PH_RD_CMD,
        PH_RD_DATA,
        PH_DONE,
        PH_FAIL
    } phase_e;

    localparam logic [7:0] OP_RST_EN = 8'h66;
    localparam logic [7:0] OP_RST_GO = 8'h99;
    localparam logic [7:0] OP_ID     = 8'h9F;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam int         FRAME_W   = 32;
endpackage

// File: rtl/fboot_shift.sv
module fboot_shift #(
    parameter int HALF_DIV = 4,
    parameter int GAP_SCK  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [5:0]  nbits,
    input  logic [31:0] tx,
    input  logic        keep,
    input  logic        miso,
    output logic        cs_n,
    output logic        sck,
    output logic        mosi,
    output logic [31:0] rx,
    output logic        done
);
    localparam int GAP_CYC = GAP_SCK * 2 * HALF_DIV;
    localparam int TMAX    = (GAP_CYC > HALF_DIV) ? GAP_CYC : HALF_DIV;
    localparam int TW      = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HALF_LD = TW'(HALF_DIV - 1);
    localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);

    typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH, E_GAP} eph_e;

    typedef struct packed {
        eph_e        ph;
        logic [TW-1:0] tmr;
        logic [5:0]  left;
        logic [31:0] sh;
        logic [31:0] rx;
        logic        keep;
        logic        cs_n;
        logic        sck;
        logic        done;
    } eng_t;

    eng_t e_q, e_d;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        case (e_q.ph)
            E_IDLE: begin
                if (start) begin
                    e_d.cs_n = 1'b0;
                    e_d.sh   = tx;
                    e_d.left = nbits;
                    e_d.keep = keep;
                    e_d.tmr  = HALF_LD;
                    e_d.ph   = E_LOW;
                end
            end
            E_LOW: begin
                if (e_q.tmr == '0) begin
                    e_d.sck = 1'b1;
                    e_d.rx  = {e_q.rx[30:0], miso};
                    e_d.tmr = HALF_LD;
                    e_d.ph  = E_HIGH;
                end else begin
                    e_d.tmr = e_q.tmr - 1'b1;
                end
            end
            E_HIGH: begin
                if (e_q.tmr == '0) begin
                    e_d.sck = 1'b0;
                    if (e_q.left == 6'd1) begin
                        if (e_q.keep) begin
                            e_d.ph   = E_IDLE;
                            e_d.done = 1'b1;
                        end else begin
                            e_d.cs_n = 1'b1;
                            e_d.tmr  = GAP_LD;
                            e_d.ph   = E_GAP;
                        end
                    end else begin
                        e_d.sh   = {e_q.sh[30:0], 1'b1};
                        e_d.left = e_q.left - 1'b1;
                        e_d.tmr  = HALF_LD;
                        e_d.ph   = E_LOW;
                    end
                end else begin
                    e_d.tmr = e_q.tmr - 1'b1;
                end
            end
            default: begin
                if (e_q.tmr == '0) begin
                    e_d.ph   = E_IDLE;
                    e_d.done = 1'b1;
                end else begin
                    e_d.tmr = e_q.tmr - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q      <= '0;
            e_q.ph   <= E_IDLE;
            e_q.cs_n <= 1'b1;
            e_q.sh   <= '1;
        end else begin
            e_q <= e_d;
        end
    end

    assign cs_n = e_q.cs_n;
    assign sck  = e_q.sck;
    assign mosi = e_q.sh[31];
    assign rx   = e_q.rx;
    assign done = e_q.done;
endmodule

// File: rtl/fboot_timer.sv
module fboot_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);
endmodule

// File: rtl/fboot_seq.sv
module fboot_seq
    import fboot_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int GAP_SCK     = 2,
    parameter int TIMEOUT_CYC = 30_000_000,
    parameter int READ_BYTES  = 256
) (
    input  logic       clk,
    input  logic       rst,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       flash_io2,
    output logic       flash_io3,
    output logic [7:0] rd_byte,
    output logic       rd_valid,
    output logic       boot_done,
    output logic       boot_fail
);
    localparam int BCW = $clog2(READ_BYTES + 1);
    localparam logic [BCW-1:0] LAST_BYTE = BCW'(READ_BYTES - 1);

    typedef struct packed {
        phase_e         phase;
        logic           busy;
        logic           start;
        logic [BCW-1:0] nbyte;
        logic [7:0]     byte_o;
        logic           valid;
        logic           done;
        logic           fail;
    } seq_t;

    seq_t s_q, s_d;

    logic [5:0]  x_bits;
    logic [31:0] x_tx;
    logic        x_keep;
    logic        eng_done;
    logic [31:0] eng_rx;
    logic        tmo;
    logic        id_ok;

    // Frame shape per phase; the engine latches it with the start pulse.
    always_comb begin
        x_bits = 6'd8;
        x_tx   = '1;
        x_keep = 1'b0;
        case (s_q.phase)
            PH_EXIT_D:  x_bits = 6'd16;
            PH_EXIT_N:  x_bits = 6'd2;
            PH_RST_EN:  x_tx   = {OP_RST_EN, 24'hFF_FFFF};
            PH_RST_GO:  x_tx   = {OP_RST_GO, 24'hFF_FFFF};
            PH_ID: begin
                x_bits = 6'(FRAME_W);
                x_tx   = {OP_ID, 24'hFF_FFFF};
            end
            PH_RD_CMD: begin
                x_bits = 6'(FRAME_W);
                x_tx   = {OP_READ, 24'h00_0000};
                x_keep = 1'b1;
            end
            PH_RD_DATA: x_keep = (s_q.nbyte != LAST_BYTE);
            default: ;
        endcase
    end

    assign id_ok = (eng_rx[23:16] != 8'h00) && (eng_rx[23:16] != 8'hFF);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.valid = 1'b0;
        if (s_q.phase != PH_DONE && s_q.phase != PH_FAIL) begin
            if (!s_q.busy) begin
                s_d.start = 1'b1;
                s_d.busy  = 1'b1;
            end else if (eng_done) begin
                s_d.busy = 1'b0;
                case (s_q.phase)
                    PH_EXIT_Q: s_d.phase = PH_EXIT_D;
                    PH_EXIT_D: s_d.phase = PH_EXIT_N;
                    PH_EXIT_N: s_d.phase = PH_RST_EN;
                    PH_RST_EN: s_d.phase = PH_RST_GO;
                    PH_RST_GO: s_d.phase = PH_ID;
                    PH_ID: begin
                        if (id_ok) begin
                            s_d.phase = PH_RD_CMD;
                        end else if (tmo) begin
                            s_d.phase = PH_FAIL;
                            s_d.fail  = 1'b1;
                        end
                    end
                    PH_RD_CMD: s_d.phase = PH_RD_DATA;
                    default: begin
                        s_d.byte_o = eng_rx[7:0];
                        s_d.valid  = 1'b1;
                        if (s_q.nbyte == LAST_BYTE) begin
                            s_d.phase = PH_DONE;
                            s_d.done  = 1'b1;
                        end else begin
                            s_d.nbyte = s_q.nbyte + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.phase <= PH_EXIT_Q;
        end else begin
            s_q <= s_d;
        end
    end

    fboot_shift #(.HALF_DIV(HALF_DIV), .GAP_SCK(GAP_SCK)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (s_q.start),
        .nbits (x_bits),
        .tx    (x_tx),
        .keep  (x_keep),
        .miso  (spi_miso),
        .cs_n  (spi_cs_n),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .rx    (eng_rx),
        .done  (eng_done)
    );

    fboot_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (s_q.phase == PH_ID),
        .expired (tmo)
    );

    assign flash_io2 = 1'b1;
    assign flash_io3 = 1'b1;
    assign rd_byte   = s_q.byte_o;
    assign rd_valid  = s_q.valid;
    assign boot_done = s_q.done;
    assign boot_fail = s_q.fail;
endmodule

// File: rtl/fboot_checker.sv
module fboot_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic valid,
    input logic done,
    input logic fail
);
    // R7: clock rests low outside a frame
    a_r7_sck_low_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R7: data output only moves in the low half of SCK
    a_r7_mosi_low_phase: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> !sck);

    // R6: byte strobe lasts a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R11: outcomes exclusive and sticky
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
    a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    a_r11_fail_holds: assert property (@(posedge clk) disable iff (rst)
        fail |=> fail);

    // R4: after giving up the bus stays quiet
    a_r4_fail_quiet: assert property (@(posedge clk) disable iff (rst)
        fail |-> (cs_n && !valid));

    // R9: reset returns the pins and flags to idle
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (cs_n && !sck && !done && !fail));
endmodule

bind fboot_seq fboot_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (spi_cs_n),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .valid (rd_valid),
    .done  (boot_done),
    .fail  (boot_fail)
);

// File: tb/fboot_seq_test.sv
`timescale 1ns/1ps
module fboot_seq_test;
    localparam int HALF_DIV = 2;
    localparam int GAP_SCK  = 2;
    localparam int TMO      = 2000;
    localparam int NBYTES   = 4;
    localparam int FRAME_CYC = 32 * 2 * HALF_DIV + GAP_SCK * 2 * HALF_DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n, sck, mosi, io2, io3, rd_valid, done, fail;
    logic [7:0] rd_byte;
    logic miso_r = 1'b1;

    always #2 clk = ~clk;

    fboot_seq #(.HALF_DIV(HALF_DIV), .GAP_SCK(GAP_SCK), .TIMEOUT_CYC(TMO),
                .READ_BYTES(NBYTES)) uut (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso_r), .flash_io2(io2), .flash_io3(io3), .rd_byte(rd_byte),
        .rd_valid(rd_valid), .boot_done(done), .boot_fail(fail));

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    typedef struct { int bits; logic [31:0] head; } frame_t;
    frame_t fq[$];
    logic [7:0] bq[$];

    int dev_mode = 0;      // 0 answers, 1 absent (pulled high), 2 all zeros
    int ready_after = 0;   // ID frames before a real answer
    int id_done = 0;
    int id_extra = 0;
    int frame_idx = 0;
    longint cyc = 0;
    longint t_id0 = 0;
    int nb = 0;
    logic [31:0] head = '0;
    logic [7:0] cmd = '0;

    function automatic logic [7:0] data_of(input int k);
        return 8'hA5 ^ 8'(k * 29);
    endfunction

    function automatic logic out_bit(input int n);
        logic [23:0] id24;
        logic [7:0] d;
        if (n < 8) return 1'b1;
        if (cmd == 8'h9F && n < 32) begin
            if (dev_mode == 2) return 1'b0;
            if (dev_mode == 1 || id_done < ready_after) return 1'b1;
            id24 = 24'hC2_2018;
            return id24[31 - n];
        end
        if (cmd == 8'h03 && n >= 32) begin
            d = data_of((n - 32) / 8);
            return d[7 - ((n - 32) % 8)];
        end
        return 1'b1;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge cs_n) begin
        nb = 0; head = '0; cmd = '0;
        if (frame_idx == 5) t_id0 = cyc;
        frame_idx++;
        miso_r = 1'b1;
    end

    always @(posedge sck) if (!cs_n) begin
        if (nb < 32) head = {head[30:0], mosi};
        nb++;
        if (nb == 8) cmd = head[7:0];
    end

    always @(negedge sck) if (!cs_n) miso_r = out_bit(nb);

    // frame scoreboard monitor
    always @(posedge cs_n) if (!rst) begin
        if (cmd == 8'h9F && nb == 32) id_done++;
        if (fq.size() > 0) begin
            frame_t e;
            e = fq.pop_front();
            check(nb == e.bits, "R1/R2/R3/R5 frame clocks", nb, e.bits);
            check(head == e.head, "R1/R2/R3/R5 frame head", head, e.head);
        end else if (cmd == 8'h9F && nb == 32) begin
            id_extra++;
        end else begin
            check(1'b0, "R4 unexpected frame", nb, 0);
        end
    end

    // byte scoreboard monitor
    always @(negedge clk) if (!rst && rd_valid) begin
        if (bq.size() > 0) begin
            logic [7:0] eb;
            eb = bq.pop_front();
            check(rd_byte == eb, "R6 byte", rd_byte, eb);
        end else begin
            check(1'b0, "R6 extra byte", rd_byte, 0);
        end
    end

    // R8 chip-select gap monitor
    int hi_run = 0;
    bit seen_frame = 0;
    always @(negedge clk) begin
        if (rst) begin
            hi_run = 0; seen_frame = 0;
        end else if (cs_n) begin
            hi_run++;
        end else begin
            if (hi_run > 0 && seen_frame)
                check(hi_run >= GAP_SCK * 2 * HALF_DIV, "R8 cs gap", hi_run, GAP_SCK * 2 * HALF_DIV);
            if (hi_run > 0) seen_frame = 1;
            hi_run = 0;
        end
        if (!rst) check(io2 && io3, "R10 io high", {io2, io3}, 2'b11);
    end

    // ---------------- driver ----------------
    task automatic push_seq(input int n_id, input bit with_read);
        fq.push_back('{8,  32'h0000_00FF});
        fq.push_back('{16, 32'h0000_FFFF});
        fq.push_back('{2,  32'h0000_0003});
        fq.push_back('{8,  32'h0000_0066});
        fq.push_back('{8,  32'h0000_0099});
        for (int i = 0; i < n_id; i++) fq.push_back('{32, 32'h9FFF_FFFF});
        if (with_read) begin
            fq.push_back('{32 + 8 * NBYTES, 32'h0300_0000});
            for (int k = 0; k < NBYTES; k++) bq.push_back(data_of(k));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        fq.delete(); bq.delete();
        id_done = 0; id_extra = 0; frame_idx = 0;
    endtask

    task automatic wait_end(input string tag);
        int k;
        for (k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done || fail) break;
        end
        if (k == 20000) check(1'b0, {tag, " watchdog"}, 0, 1);
    endtask

    longint t_fail;

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0, "R9 reset pins", {cs_n, sck}, 2'b10);
        check(!done && !fail && !rd_valid, "R9 reset flags", {done, fail, rd_valid}, 0);

        // A: device ready on fourth poll
        do_reset();
        dev_mode = 0; ready_after = 3;
        push_seq(4, 1'b1);
        rst = 1'b0;
        wait_end("A");
        repeat (20) @(negedge clk);
        check(done && !fail, "R6 done A", {done, fail}, 2'b10);
        check(cs_n, "R6 cs released", cs_n, 1);
        check(fq.size() == 0, "R3 frames left A", fq.size(), 0);
        check(bq.size() == 0, "R6 bytes left A", bq.size(), 0);
        check(id_extra == 0, "R3 extra polls", id_extra, 0);

        // B: absent device, bus pulled high
        do_reset();
        dev_mode = 1;
        push_seq(0, 1'b0);
        rst = 1'b0;
        wait_end("B");
        t_fail = cyc;
        repeat (20) @(negedge clk);
        check(fail && !done, "R4 fail B", {done, fail}, 2'b01);
        check(t_fail >= t_id0 + TMO - 4, "R4 not early", t_fail - t_id0, TMO);
        check(t_fail <= t_id0 + TMO + FRAME_CYC + 20, "R4 not late", t_fail - t_id0, TMO);
        check(id_extra > 2, "R3 repeated polls", id_extra, 3);

        // C: device answering all zeros
        do_reset();
        dev_mode = 2;
        push_seq(0, 1'b0);
        rst = 1'b0;
        wait_end("C");
        repeat (20) @(negedge clk);
        check(fail && !done, "R3 zero id rejected", {done, fail}, 2'b01);
        check(cs_n, "R4 cs idle", cs_n, 1);

        // D: reset in the middle of polling, then a ready device
        do_reset();
        dev_mode = 0; ready_after = 1000;
        push_seq(0, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < 20000 && id_extra < 2; k++) @(negedge clk);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(cs_n && !sck && !done && !fail, "R9 mid reset", {cs_n, sck, done, fail}, 4'b1000);
        do_reset();
        ready_after = 0;
        push_seq(1, 1'b1);
        rst = 1'b0;
        wait_end("D");
        repeat (20) @(negedge clk);
        check(done && !fail, "R9 restart done", {done, fail}, 2'b10);
        check(fq.size() == 0 && bq.size() == 0, "R9 restart sequence", fq.size() + bq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule